// File: doc/BRIEF.md
# Watchdog Timer with Register Interface

This block is a watchdog for a larger chip. Software talks to it over a small register bus with an address, a write strobe, write data and combinational read data. Software picks two timeout ranges, one for the first period after the watchdog is armed and one for every later period. It then arms the watchdog, which cannot be disarmed again short of a system reset. From then on software has to restart the countdown on a regular basis by writing a fixed key. If the countdown runs out, the block asks the system for a reset. In warning mode it raises an interrupt first and only asks for the reset if a second period also runs out.

The control path is a three-state machine:

- **ST_OFF**: the watchdog is disarmed.
- **ST_COUNT**: the watchdog is counting normally.
- **ST_WARN**: a warning has been issued and the interrupt is pending.

The transitions between states are:

- **OFF→COUNT** when the watchdog is armed. The counter loads the first-period range.
- **COUNT→COUNT** on a valid kick, or on an expiry in reset mode. The counter reloads the restart range.
- **COUNT→WARN** on an expiry in warning mode. The interrupt is set and the counter reloads.
- **WARN→COUNT** on a valid kick, which clears the interrupt.
- **WARN→COUNT** on a second expiry, which raises the reset request.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the interrupt and the reset request are low, the watchdog is disarmed, and every register reads zero.
- R2: Offset 0x00 is the control register. Bit 0 arms the watchdog and reads back its state. Bit 1 selects the response: 0 is reset mode, 1 is warning mode. All other bits read zero.
- R3: Once the arm bit is set, writing 0 to it leaves it at 1. Only the block reset clears it.
- R4: Offset 0x04 holds two range codes. Bits 3:0 are the restart range and bits 7:4 are the first-period range. Bits 31:8 read zero. Offset 0x0C and every unlisted offset read zero.
- R5: A range code c gives a period of 2^(RANGE_BASE+c) cycles. After the arming write, the counter loads 2^(RANGE_BASE+first)-1 on the following edge and then decrements once per cycle.
- R6: A write of exactly 0x00000076 to offset 0x0C reloads the counter from the restart range. Any other value written there is ignored.
- R7: A key write while the watchdog is disarmed has no effect. While disarmed, the interrupt and the reset request stay low.
- R8: In reset mode, the edge on which the counter is at zero raises the reset request for exactly one cycle and reloads the counter from the restart range.
- R9: In warning mode, the first expiry sets the interrupt and reloads the counter. A second expiry before any kick raises the one-cycle reset request and clears the interrupt. A valid kick clears the interrupt.
- R10: A write to the range register does not change a countdown in progress. The new code is used only at the next reload.
- R11: A valid kick on the same edge as an expiry takes priority. The counter reloads, and neither the interrupt nor the reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| wdt_irq | output | 1 | Warning interrupt, held until a kick or a second expiry |
| wdt_reset_req | output | 1 | One-cycle system reset request |

## Verification
Two events can fall on the same edge: the counter running out and a valid key write. The bench provokes this by following a cycle-accurate reference model of the countdown and issuing the key write so that it lands on the edge where the model's count is zero. It does this in both response modes.

A correct result is an ordinary reload with the interrupt and the reset request both staying low, checked on every following cycle against the model. Random traffic adds further accidental collisions, and also range writes that land in the middle of a count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_WARN  = 2'd2
    } wdt_state_e;

    localparam int unsigned OFS_CTRL  = 32'h00;
    localparam int unsigned OFS_RANGE = 32'h04;
    localparam int unsigned OFS_KICK  = 32'h0C;
    localparam int unsigned KICK_KEY  = 32'h76;
    localparam int unsigned RANGE_CODES = 16;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              arm,
    output logic              warn_mode,
    output logic [3:0]        first_rng,
    output logic [3:0]        restart_rng,
    output logic              kick_ok
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_RANGE = ADDR_W'(OFS_RANGE);
    localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFS_KICK);
    localparam logic [DATA_W-1:0] KEY     = DATA_W'(KICK_KEY);

    logic       arm_q;
    logic       mode_q;
    logic [3:0] first_q;
    logic [3:0] restart_q;

    wire wr_ctrl  = we && (addr == A_CTRL);
    wire wr_range = we && (addr == A_RANGE);

    // Arm bit is sticky: OR-in only, cleared by reset alone.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q     <= 1'b0;
            mode_q    <= 1'b0;
            first_q   <= 4'd0;
            restart_q <= 4'd0;
        end else begin
            if (wr_ctrl) begin
                arm_q  <= arm_q | wdata[0];
                mode_q <= wdata[1];
            end
            if (wr_range) begin
                restart_q <= wdata[3:0];
                first_q   <= wdata[7:4];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[0] = arm_q;
            rdata[1] = mode_q;
        end else if (addr == A_RANGE) begin
            rdata[3:0] = restart_q;
            rdata[7:4] = first_q;
        end
    end

    assign kick_ok     = we && (addr == A_KICK) && (wdata == KEY) && arm_q;
    assign arm         = arm_q;
    assign warn_mode   = mode_q;
    assign first_rng   = first_q;
    assign restart_rng = restart_q;

endmodule

// File: rtl/wdt_range_dec.sv
module wdt_range_dec
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int RANGE_BASE = 16
) (
    input  logic [3:0]       code,
    output logic [CNT_W-1:0] reload
);

    localparam int MAX_SHIFT = RANGE_BASE + RANGE_CODES - 1;

    logic [CNT_W-1:0] tbl [RANGE_CODES];

    // Reload value for each code: 2^(RANGE_BASE+g) - 1.
    for (genvar g = 0; g < RANGE_CODES; g++) begin : g_tbl
        localparam longint unsigned PERIOD = 64'd1 << (RANGE_BASE + g);
        assign tbl[g] = CNT_W'(PERIOD - 64'd1);
    end

    assign reload = tbl[code];

    initial begin
        if (MAX_SHIFT > CNT_W) $display("wdt_range_dec: counter too narrow for range set");
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             at_zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       warn_mode,
    input  logic       kick,
    input  logic       at_zero,
    output logic       load,
    output logic       use_first,
    output logic       run,
    output logic       irq,
    output logic       reset_req
);

    wdt_state_e state_q, state_d;
    logic fire_irq, fire_rst;
    logic irq_q, rst_q;

    // Next state and counter control; kick outranks expiry.
    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        use_first = 1'b0;
        fire_irq  = 1'b0;
        fire_rst  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (arm) begin
                    load      = 1'b1;
                    use_first = 1'b1;
                    state_d   = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (kick) begin
                    load = 1'b1;
                end else if (at_zero) begin
                    load = 1'b1;
                    if (warn_mode) begin
                        fire_irq = 1'b1;
                        state_d  = ST_WARN;
                    end else begin
                        fire_rst = 1'b1;
                    end
                end
            end
            ST_WARN: begin
                if (kick) begin
                    load    = 1'b1;
                    state_d = ST_COUNT;
                end else if (at_zero) begin
                    load     = 1'b1;
                    fire_rst = 1'b1;
                    state_d  = ST_COUNT;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            rst_q <= fire_rst;
            if (kick || fire_rst) irq_q <= 1'b0;
            else if (fire_irq)    irq_q <= 1'b1;
        end
    end

    assign run       = (state_q != ST_OFF);
    assign irq       = irq_q;
    assign reset_req = rst_q;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 32,
    parameter int RANGE_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_irq,
    output logic              wdt_reset_req
);

    logic             arm, warn_mode, kick_ok;
    logic [3:0]       first_rng, restart_rng, sel_rng;
    logic [CNT_W-1:0] reload_val;
    logic             load, use_first, run, at_zero;

    wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .we         (bus_we),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .arm        (arm),
        .warn_mode  (warn_mode),
        .first_rng  (first_rng),
        .restart_rng(restart_rng),
        .kick_ok    (kick_ok)
    );

    assign sel_rng = use_first ? first_rng : restart_rng;

    wdt_range_dec #(.CNT_W(CNT_W), .RANGE_BASE(RANGE_BASE)) u_dec (
        .code  (sel_rng),
        .reload(reload_val)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(reload_val),
        .run     (run),
        .at_zero (at_zero)
    );

    wdt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .warn_mode(warn_mode),
        .kick     (kick_ok),
        .at_zero  (at_zero),
        .load     (load),
        .use_first(use_first),
        .run      (run),
        .irq      (wdt_irq),
        .reset_req(wdt_reset_req)
    );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
    input logic clk,
    input logic rst_n,
    input logic arm,
    input logic warn_mode,
    input logic kick,
    input logic irq,
    input logic reset_req
);

    a_r3_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> arm);

    a_r8_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    a_r7_quiet_when_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |-> (!irq && !reset_req));

    a_r9_irq_needs_warn_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(warn_mode));

    a_r9_reset_after_warning: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && $past(warn_mode)) |-> $past(irq));

    a_r11_kick_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (!irq && !reset_req));

endmodule

bind wdog_timer wdt_checker u_wdt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .warn_mode(warn_mode),
    .kick     (kick_ok),
    .irq      (wdt_irq),
    .reset_req(wdt_reset_req)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;

    localparam int B = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rreq;

    always #2 clk = ~clk;

    wdog_timer #(.RANGE_BASE(B)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata),
        .wdt_irq(irq), .wdt_reset_req(rreq)
    );

    int vecs = 0, bad = 0;
    string tag = "R1";

    // Reference model (from requirements)
    bit     m_arm, m_mode, m_irq, m_rreq;
    bit [3:0] m_first, m_rest;
    int     m_state;   // 0 off, 1 count, 2 warn
    longint m_cnt;

    function automatic longint period(input bit [3:0] c);
        return longint'(1) << (B + c);
    endfunction

    function automatic bit [31:0] exp_rd(input bit [7:0] a);
        if (a == 8'h00) return {30'd0, m_mode, m_arm};
        if (a == 8'h04) return {24'd0, m_first, m_rest};
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_arm = 0; m_mode = 0; m_irq = 0; m_rreq = 0;
            m_first = 0; m_rest = 0; m_state = 0; m_cnt = 0;
        end else begin
            bit kick;
            kick = we && addr == 8'h0C && wdata == 32'h76 && m_arm;
            m_rreq = 0;
            if (m_state == 0) begin
                if (m_arm) begin m_cnt = period(m_first) - 1; m_state = 1; end
            end else if (kick) begin
                m_cnt = period(m_rest) - 1; m_irq = 0; m_state = 1;
            end else if (m_cnt == 0) begin
                m_cnt = period(m_rest) - 1;
                if (m_state == 2 || !m_mode) begin
                    m_rreq = 1; m_irq = 0; m_state = 1;
                end else begin
                    m_irq = 1; m_state = 2;
                end
            end else begin
                m_cnt = m_cnt - 1;
            end
            if (we && addr == 8'h00) begin m_arm = m_arm | wdata[0]; m_mode = wdata[1]; end
            if (we && addr == 8'h04) begin m_rest = wdata[3:0]; m_first = wdata[7:4]; end
        end
    end

    task automatic chk(input string t, input longint act, input longint exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
        end
    endtask

    // Wait for negedge, compare all outputs, then drive the next inputs.
    task automatic step(input bit w, input bit [7:0] a, input bit [31:0] d);
        @(negedge clk);
        if (rst_n) begin
            chk({tag, " irq"}, irq, m_irq);
            chk({tag, " reset_req"}, rreq, m_rreq);
            chk({tag, " rdata"}, rdata, exp_rd(addr));
        end
        we = w; addr = a; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; we = 0; addr = 0; wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic kick_at_zero();
        while (!(m_state != 0 && m_cnt == 1)) step(0, 8'h00, 0);
        step(1, 8'h0C, 32'h76);
        step(0, 8'h00, 0);
        chk("R11 collision irq", irq, 0);
        chk("R11 collision reset_req", rreq, 0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int n;
        bit [31:0] r;
        void'($urandom(32'd1234));
        do_reset();
        // R1 reset state
        tag = "R1";
        step(0, 8'h00, 0); step(0, 8'h04, 0); step(0, 8'h0C, 0); step(0, 8'h08, 0);
        chk("R1 irq low", irq, 0);
        chk("R1 reset_req low", rreq, 0);
        // R4 range register and upper bits
        tag = "R4";
        step(1, 8'h04, 32'hFFFF_FF21);
        step(0, 8'h04, 0); step(0, 8'h04, 0);
        chk("R4 range readback", rdata, 32'h21);
        step(0, 8'h10, 0); step(0, 8'hFC, 0);
        chk("R4 unmapped read", rdata, 0);
        // R7 kick while disarmed
        tag = "R7";
        step(1, 8'h0C, 32'h76); idle(5);
        chk("R7 still disarmed", exp_rd(8'h00) & 1, 0);
        // R5 first period, R8 reset mode
        tag = "R5";
        step(1, 8'h00, 32'h1);
        n = 0;
        do begin step(0, 8'h00, 0); n++; end while (!rreq && n < 500);
        chk("R5 cycles to first reset", n, period(2) + 2);
        tag = "R8";
        step(0, 8'h00, 0);
        chk("R8 reset one cycle", rreq, 0);
        // R3 sticky arm
        tag = "R3";
        step(1, 8'h00, 32'h0); step(0, 8'h00, 0); step(0, 8'h00, 0);
        chk("R3 arm stays set", rdata[0], 1);
        // R2 control readback with mode
        tag = "R2";
        step(1, 8'h00, 32'hFFFF_FFFE); step(0, 8'h00, 0); step(0, 8'h00, 0);
        chk("R2 ctrl readback", rdata, 32'h3);
        // R6 wrong keys ignored, right key reloads
        tag = "R6";
        for (int k = 0; k < 40; k++) begin
            step(1, 8'h0C, (k % 2) ? 32'h77 : 32'h176);
        end
        step(1, 8'h0C, 32'h76);
        idle(10);
        // R9 warning then reset
        tag = "R9";
        n = 0;
        do begin step(0, 8'h00, 0); n++; end while (!irq && n < 500);
        chk("R9 irq raised", irq, 1);
        step(1, 8'h0C, 32'h76); step(0, 8'h00, 0);
        chk("R9 kick clears irq", irq, 0);
        n = 0;
        do begin step(0, 8'h00, 0); n++; end while (!rreq && n < 500);
        chk("R9 second expiry resets", rreq, 1);
        // R10 range change mid-count
        tag = "R10";
        step(1, 8'h0C, 32'h76);
        idle(3);
        step(1, 8'h04, 32'h00);
        idle(200);
        // R11 collisions in both modes
        tag = "R11";
        kick_at_zero();
        step(1, 8'h00, 32'h1);
        kick_at_zero();
        // random traffic
        tag = "R6/R10 random";
        do_reset();
        for (int i = 0; i < 12000; i++) begin
            r = $urandom % 100;
            if (r < 3)       step(1, 8'h0C, 32'h76);
            else if (r < 4)  step(1, 8'h0C, $urandom);
            else if (r < 5)  step(1, 8'h04, {24'd0, 2'd0, 2'($urandom), 2'd0, 2'($urandom)});
            else if (r < 7)  step(1, 8'h00, {30'd0, 2'($urandom)});
            else             step(0, 8'(($urandom % 6) * 4), 0);
        end
        idle(2);
        finish_run();
    end

endmodule